// File: doc/BRIEF.md
# Read-Coherent Position Latch with Byte Bus

This block sits between a free-running up/down position counter and a narrow host bus. It keeps a position word in a latch that copies the counter on every rising clock edge. A host reads that word one byte at a time over an 8-bit bus. The bus is modelled as a data word plus a drive-enable, which stands in for a three-state driver.

A two-byte read must not return a high byte from one sample and a low byte from another. To prevent this, a small freeze controller watches the byte select and the active-low output enable on the falling clock edge. The controller has three states:

- `ST_TRACK`: the latch follows the counter.
- `ST_FROZEN`: entered when the high byte is read (output enable low, select low). The latch holds.
- `ST_UNFREEZE`: entered from `ST_FROZEN` when the low byte is read (output enable low, select high). The latch still holds.

Leaving `ST_UNFREEZE` to `ST_TRACK` needs a falling-edge sample with output enable high. A new high-byte read in `ST_UNFREEZE` returns the controller to `ST_FROZEN`. A low-byte read in `ST_TRACK` does not freeze.

An asynchronous active-low reset clears the latch to zero and forces `ST_TRACK`. A parameter selects a narrower latch, for example 12 bits. In that case the unused upper bits of the high byte always read as zero.

Top module: `posn_read_latch`

## Requirements
- R1: While `rst_n` is low, the latch reads as zero at once, without waiting for a clock edge, and the controller is in `ST_TRACK`.
- R2: In `ST_TRACK`, each rising clock edge loads `count_in` into the latch.
- R3: `bus_drv` equals the inverse of `oe_n`. `bus_out` is zero whenever `oe_n` is high. `sel`=0 presents latch bits [15:8] and `sel`=1 presents bits [7:0].
- R4: In `ST_TRACK`, a falling-edge sample of `oe_n`=0 with `sel`=0 enters `ST_FROZEN`. From the next rising edge on, the latch keeps its value.
- R5: In `ST_FROZEN`, a falling-edge sample of `oe_n`=0 with `sel`=1 enters `ST_UNFREEZE`. The latch still keeps its value.
- R6: In `ST_UNFREEZE`, a falling-edge sample of `oe_n`=1 returns to `ST_TRACK`, whatever `sel` is. The next rising edge loads `count_in` again.
- R7: In `ST_FROZEN`, a falling-edge sample of `oe_n`=1 leaves the controller in `ST_FROZEN`.
- R8: In `ST_TRACK`, a low-byte read (`oe_n`=0, `sel`=1) does not freeze the latch.
- R9: In `ST_UNFREEZE`, a falling-edge sample of `oe_n`=0 with `sel`=0 returns to `ST_FROZEN`.
- R10: With `POS_W`=12, bits [7:4] of the high byte always read as zero. The low byte and bits [3:0] of the high byte carry the latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the latch loads on the rising edge, the controller samples on the falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe_n | input | 1 | Output enable, active low |
| sel | input | 1 | Byte select: 0 selects the high byte, 1 selects the low byte |
| count_in | input | 16 | Position value from the counter |
| bus_out | output | 8 | Byte presented on the bus; zero when not driven |
| bus_drv | output | 1 | Bus drive enable; stands for the three-state enable |

## Verification
The hardest cases to reach are the ones where the latch must stay frozen even though the inputs look like a finished read.

- An idle cycle with `oe_n` high after only the high-byte read must not release the latch (R7).
- A second high-byte read after the low-byte read must put the controller back to `ST_FROZEN` (R9).

Neither state is visible at the ports. The stimulus table therefore changes `count_in` on every row. Each row is followed by a later low-byte read. If the latch had been released early, that read would return a different value.

// File: rtl/posn_pkg.sv
package posn_pkg;

    typedef enum logic [1:0] {
        ST_TRACK    = 2'd0,
        ST_FROZEN   = 2'd1,
        ST_UNFREEZE = 2'd2
    } inhib_state_t;

endpackage

// File: rtl/posn_freeze_fsm.sv
module posn_freeze_fsm
    import posn_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         sel,
    output inhib_state_t state_q,
    output logic         freeze
);

    inhib_state_t state_d;

    // State register: falling edge, asynchronous clear.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK: begin
                if (!oe_n && !sel) begin
                    state_d = ST_FROZEN;
                end
            end
            ST_FROZEN: begin
                if (!oe_n && sel) begin
                    state_d = ST_UNFREEZE;
                end
            end
            ST_UNFREEZE: begin
                if (oe_n) begin
                    state_d = ST_TRACK;
                end else if (!sel) begin
                    state_d = ST_FROZEN;
                end
            end
            default: state_d = ST_TRACK;
        endcase
    end

    // Output logic.
    always_comb begin
        unique case (state_q)
            ST_TRACK: freeze = 1'b0;
            default:  freeze = 1'b1;
        endcase
    end

endmodule

// File: rtl/posn_hold_reg.sv
module posn_hold_reg #(
    parameter int WORD_W = 16,
    parameter int POS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic [WORD_W-1:0] count_in,
    output logic [POS_W-1:0]  pos_q,
    output logic [WORD_W-1:0] word
);

    localparam int PAD_W = WORD_W - POS_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (!freeze) begin
            pos_q <= count_in[POS_W-1:0];
        end
    end

    generate
        if (PAD_W > 0) begin : g_narrow
            assign word = {{PAD_W{1'b0}}, pos_q};
        end else begin : g_full
            assign word = pos_q;
        end
    endgenerate

endmodule

// File: rtl/posn_byte_mux.sv
module posn_byte_mux #(
    parameter int BUS_W = 8
) (
    input  logic [2*BUS_W-1:0] word,
    input  logic               oe_n,
    input  logic               sel,
    output logic [BUS_W-1:0]   bus_out,
    output logic               bus_drv
);

    logic [BUS_W-1:0] hi_byte;
    logic [BUS_W-1:0] lo_byte;

    assign hi_byte = word[2*BUS_W-1:BUS_W];
    assign lo_byte = word[BUS_W-1:0];
    assign bus_drv = ~oe_n;

    always_comb begin
        if (oe_n) begin
            bus_out = '0;
        end else if (sel) begin
            bus_out = lo_byte;
        end else begin
            bus_out = hi_byte;
        end
    end

endmodule

// File: rtl/posn_read_latch.sv
module posn_read_latch
    import posn_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int POS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               oe_n,
    input  logic               sel,
    input  logic [2*BUS_W-1:0] count_in,
    output logic [BUS_W-1:0]   bus_out,
    output logic               bus_drv
);

    localparam int WORD_W = 2 * BUS_W;

    inhib_state_t      inhib_st;
    logic              freeze;
    logic [POS_W-1:0]  pos_q;
    logic [WORD_W-1:0] word;

    posn_freeze_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_n    (oe_n),
        .sel     (sel),
        .state_q (inhib_st),
        .freeze  (freeze)
    );

    posn_hold_reg #(
        .WORD_W (WORD_W),
        .POS_W  (POS_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze   (freeze),
        .count_in (count_in),
        .pos_q    (pos_q),
        .word     (word)
    );

    posn_byte_mux #(
        .BUS_W (BUS_W)
    ) u_mux (
        .word    (word),
        .oe_n    (oe_n),
        .sel     (sel),
        .bus_out (bus_out),
        .bus_drv (bus_drv)
    );

endmodule

// File: rtl/posn_read_chk.sv
module posn_read_chk
    import posn_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int POS_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               oe_n,
    input logic               sel,
    input logic [2*BUS_W-1:0] count_in,
    input inhib_state_t       inhib_st,
    input logic [POS_W-1:0]   pos_q,
    input logic [BUS_W-1:0]   bus_out,
    input logic               bus_drv
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (pos_q == '0 && inhib_st == ST_TRACK); // R1
        end
    end

    AST_TRACK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (inhib_st == ST_TRACK) |=> (pos_q == $past(count_in[POS_W-1:0]))); // R2

    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!bus_drv && bus_out == '0)); // R3

    AST_BUS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> bus_drv); // R3

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inhib_st != ST_TRACK) |=> $stable(pos_q)); // R4

    AST_STEP_HIGH: assert property (@(negedge clk) disable iff (!rst_n)
        (inhib_st == ST_TRACK && !oe_n && !sel) |=> (inhib_st == ST_FROZEN)); // R4

    AST_STEP_LOW: assert property (@(negedge clk) disable iff (!rst_n)
        (inhib_st == ST_FROZEN && !oe_n && sel) |=> (inhib_st == ST_UNFREEZE)); // R5

    AST_STEP_DONE: assert property (@(negedge clk) disable iff (!rst_n)
        (inhib_st == ST_UNFREEZE && oe_n) |=> (inhib_st == ST_TRACK)); // R6

    AST_NO_EARLY_RELEASE: assert property (@(negedge clk) disable iff (!rst_n)
        (inhib_st == ST_FROZEN && oe_n) |=> (inhib_st == ST_FROZEN)); // R7

    AST_LOW_NO_FREEZE: assert property (@(negedge clk) disable iff (!rst_n)
        (inhib_st == ST_TRACK && !oe_n && sel) |=> (inhib_st == ST_TRACK)); // R8

    AST_REFREEZE: assert property (@(negedge clk) disable iff (!rst_n)
        (inhib_st == ST_UNFREEZE && !oe_n && !sel) |=> (inhib_st == ST_FROZEN)); // R9

endmodule

bind posn_read_latch posn_read_chk #(
    .BUS_W (BUS_W),
    .POS_W (POS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (oe_n),
    .sel      (sel),
    .count_in (count_in),
    .inhib_st (inhib_st),
    .pos_q    (pos_q),
    .bus_out  (bus_out),
    .bus_drv  (bus_drv)
);

// File: tb/sim_posn_read_latch.sv
`timescale 1ns/1ps
module sim_posn_read_latch;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        oe_n;
    logic        sel;
    logic [15:0] count_in;
    logic [7:0]  bus_out, bus12_out;
    logic        bus_drv, bus12_drv;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    posn_read_latch #(.BUS_W(8), .POS_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .sel(sel), .count_in(count_in),
        .bus_out(bus_out), .bus_drv(bus_drv)
    );

    posn_read_latch #(.BUS_W(8), .POS_W(12)) u1 (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .sel(sel), .count_in(count_in),
        .bus_out(bus12_out), .bus_drv(bus12_drv)
    );

    // {oe_n, sel, count_in, expected bus_out, expected bus_drv}
    localparam int NV = 19;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h1234, 8'h00, 1'b0},  // 0  R3 idle
        {1'b1, 1'b1, 16'h5678, 8'h00, 1'b0},  // 1  R3 idle
        {1'b0, 1'b1, 16'h9ABC, 8'h78, 1'b1},  // 2  R2 R8 low read while tracking
        {1'b0, 1'b0, 16'hA1B2, 8'h9A, 1'b1},  // 3  R4 step one
        {1'b1, 1'b0, 16'hC3D4, 8'h00, 1'b0},  // 4  R7 gap
        {1'b0, 1'b1, 16'hE5F6, 8'hBC, 1'b1},  // 5  R5 step two, still held
        {1'b0, 1'b1, 16'h1111, 8'hBC, 1'b1},  // 6  R5
        {1'b1, 1'b1, 16'h2222, 8'h00, 1'b0},  // 7  R6 step three
        {1'b1, 1'b0, 16'h3333, 8'h00, 1'b0},  // 8  R6 tracking again
        {1'b0, 1'b0, 16'h4444, 8'h33, 1'b1},  // 9  R6 R4
        {1'b0, 1'b0, 16'h5555, 8'h33, 1'b1},  // 10 R4
        {1'b0, 1'b1, 16'h6666, 8'h33, 1'b1},  // 11 R5
        {1'b0, 1'b0, 16'h7777, 8'h33, 1'b1},  // 12 R9 refreeze
        {1'b1, 1'b1, 16'h8888, 8'h00, 1'b0},  // 13 R9
        {1'b1, 1'b0, 16'h9999, 8'h00, 1'b0},  // 14 R7
        {1'b0, 1'b1, 16'hAAAA, 8'h33, 1'b1},  // 15 R7 R9 still 3333
        {1'b1, 1'b0, 16'hBBBB, 8'h00, 1'b0},  // 16 R6
        {1'b0, 1'b1, 16'hCCCC, 8'hBB, 1'b1},  // 17 R6 R8
        {1'b0, 1'b0, 16'hDDDD, 8'hCC, 1'b1}   // 18 R8 R2
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %04h expected %04h", tag, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        oe_n     = 1'b1;
        sel      = 1'b0;
        count_in = 16'h0000;
        #5;
        oe_n = 1'b0;
        #1;
        check("R1 reset latch high byte", {8'h00, bus_out}, 16'h0000);
        check("R3 drive with oe_n low", {15'd0, bus_drv}, 16'd1);
        oe_n = 1'b1;
        #1;
        check("R3 no drive with oe_n high", {15'd0, bus_drv}, 16'd0);
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            #2;
            oe_n     = VEC[i][26];
            sel      = VEC[i][25];
            count_in = VEC[i][24:9];
            @(negedge clk);
            #2;
            check($sformatf("R2-R9 table row %0d bus", i), {8'h00, bus_out}, {8'h00, VEC[i][8:1]});
            check($sformatf("R3 table row %0d drive", i), {15'd0, bus_drv}, {15'd0, VEC[i][0]});
        end

        // R1: asynchronous reset in the middle of a frozen read
        @(posedge clk);
        #2;
        oe_n = 1'b0; sel = 1'b0; count_in = 16'hF2AB;
        #3 rst_n = 1'b0;
        #1;
        check("R1 async clear mid cycle", {8'h00, bus_out}, 16'h0000);
        oe_n = 1'b1;
        @(posedge clk);
        #5 rst_n = 1'b1;
        @(posedge clk);  // R1 tracking after reset: loads F2AB
        #2;
        oe_n = 1'b0; sel = 1'b0;
        @(negedge clk);
        #2;
        check("R1 R2 tracking after reset high", {8'h00, bus_out}, 16'h00F2);
        check("R10 narrow high byte", {8'h00, bus12_out}, 16'h0002);
        @(posedge clk);
        #2;
        sel = 1'b1; count_in = 16'h0000;
        @(negedge clk);
        #2;
        check("R5 low byte of frozen sample", {8'h00, bus_out}, 16'h00AB);
        check("R10 narrow low byte", {8'h00, bus12_out}, 16'h00AB);
        @(posedge clk);
        #2;
        oe_n = 1'b1; sel = 1'b0;
        @(posedge clk);
        @(posedge clk);  // tracking again, latched 0000
        #2;
        count_in = 16'hFFFF;
        @(posedge clk);
        #2;
        oe_n = 1'b0; sel = 1'b0;
        @(negedge clk);
        #2;
        check("R6 R2 release then load", {8'h00, bus_out}, 16'h00FF);
        check("R10 upper nibble zero", {8'h00, bus12_out}, 16'h000F);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule